// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the bus-side engine of a byte-wide serial memory that answers on a two-wire bus. It watches a clock line and an open-drain data line. The data line is split into a sampled input and a pull-low output. The block finds start and stop conditions and matches a header byte against two select pins. It collects a memory address, takes write data into a page buffer, and streams read data back one bit per bus clock. It drives the acknowledge bit where the protocol asks for one.

Written bytes are held in the page buffer until the stop that closes the write. That stop starts a self-timed write cycle lasting a fixed number of system clocks. While the cycle runs, the block ignores its own header. A host can therefore poll for completion by sending headers until one is acknowledged. Reads can start at the current address pointer or, after a header with write direction and an address byte, at any location. They continue for as long as the host acknowledges.

Top module: `serial_mem_slave`

## Requirements
- R1: A start is the data line falling while the clock line is high. A stop is the data line rising while the clock line is high. Before the first start, nothing is acknowledged. A start in the middle of a header restarts header reception. The pull-low output changes only just after a clock fall.
- R2: Header byte layout, MSB first. Bit 7 must equal `sel1`. Bit 6 must equal the inverse of `sel2`. Bits 5..1 are address bits 12..8. Bit 0 is the direction: 1 for read, 0 for write. A header that does not match gets no acknowledge.
- R3: In a write, the block pulls the data line low during the ninth clock after the header, after the low address byte and after every data byte.
- R4: Within one write, each data byte after the first goes to the next address. Only the low 5 address bits advance, and they wrap inside the 32-byte page; the upper bits stay fixed.
- R5: Bytes of a write reach the array only after the stop that ends the write. After the write cycle they read back unchanged.
- R6: For WRITE_CYCLES system clocks after that stop, a matching header gets no acknowledge. Afterwards it is acknowledged again.
- R7: A read with no address byte starts at the pointer. After a write, the pointer holds the last written address. After a read, it holds the last read address plus one.
- R8: A read continues while the host acknowledges each byte. The address advances across all 13 bits and wraps from 0x1FFF to 0x0000.
- R9: A write header with an address byte, followed by a repeated start and a read header, returns data from that address.
- R10: When the host does not acknowledge a read byte, the block releases the data line. It keeps the line released until the next start.
- R11: A stop that arrives after two or more bits of a data byte aborts the write. The array is not changed, and no write cycle starts, so the next header is acknowledged at once.
- R12: The array holds 2^MEM_AW bytes and is indexed by the low MEM_AW bits of the 13-bit address. Addresses that differ only above those bits reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Bus clock line |
| sda_in | input | 1 | Sampled level of the bus data line |
| sel1 | input | 1 | Select pin compared with header bit 7 |
| sel2 | input | 1 | Select pin whose inverse is compared with header bit 6 |
| sda_drive_low | output | 1 | Pulls the data line low when 1 |

## Verification
Most wrong internal states show up at the ports within one bus clock period. A bad bit count or header decode appears as a missing or misplaced acknowledge in the ninth clock of the same byte. A wrong pointer or page increment appears as a wrong data bit in the first read after the next write cycle. A write-cycle timer that stops early or late is seen by header polling. Polling right after the stop must get no acknowledge, and polling once WRITE_CYCLES clocks have passed must get one. An abort that still commits shows as a missing acknowledge on the next header.

// File: rtl/sms_pkg.sv
package sms_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HDR,
    ST_HACK,
    ST_ALO,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK
  } sms_state_e;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/sms_line_sync.sv
module sms_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);

  logic [1:0] line_in;
  logic [1:0] line_q;
  logic [1:0] line_d;

  assign line_in = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [SYNC_STAGES-1:0] sh;
    logic                   dly;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh  <= '1;
        dly <= 1'b1;
      end else begin
        sh  <= {sh[SYNC_STAGES-2:0], line_in[g]};
        dly <= sh[SYNC_STAGES-1];
      end
    end
    assign line_q[g] = sh[SYNC_STAGES-1];
    assign line_d[g] = dly;
  end

  assign sda_q    = line_q[0];
  assign scl_rise = line_q[1] & ~line_d[1];
  assign scl_fall = ~line_q[1] & line_d[1];
  assign start_p  = line_q[1] & line_d[1] & line_d[0] & ~line_q[0];
  assign stop_p   = line_q[1] & line_d[1] & ~line_d[0] & line_q[0];

endmodule

// File: rtl/sms_page_store.sv
module sms_page_store #(
  parameter int unsigned MEM_AW       = 10,
  parameter int unsigned PAGE_BYTES   = 32,
  parameter int unsigned WRITE_CYCLES = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_clear,
  input  logic              buf_we,
  input  logic [MEM_AW-1:0] buf_addr,
  input  logic [7:0]        buf_data,
  input  logic              commit,
  input  logic [MEM_AW-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy
);

  localparam int unsigned PG_W      = $clog2(PAGE_BYTES);
  localparam int unsigned CI_W      = PG_W + 1;
  localparam int unsigned TM_W      = $clog2(WRITE_CYCLES + 1);
  localparam int unsigned MEM_DEPTH = 1 << MEM_AW;

  logic [7:0]             mem  [MEM_DEPTH];
  logic [7:0]             pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]  vld, vld_n;
  logic [MEM_AW-PG_W-1:0] page, page_n;
  logic [TM_W-1:0]        timer, timer_n;
  logic [CI_W-1:0]        cidx, cidx_n;
  logic                   drain_open;
  logic                   drain_wr;

  assign busy       = (timer != '0);
  assign drain_open = busy && (cidx != CI_W'(PAGE_BYTES));
  assign drain_wr   = drain_open && vld[cidx[PG_W-1:0]];
  assign rd_data    = mem[rd_addr];

  always_comb begin
    vld_n   = vld;
    page_n  = page;
    timer_n = timer;
    cidx_n  = cidx;
    if (buf_clear) vld_n = '0;
    if (buf_we) begin
      vld_n[buf_addr[PG_W-1:0]] = 1'b1;
      page_n                    = buf_addr[MEM_AW-1:PG_W];
    end
    if (commit) begin
      timer_n = TM_W'(WRITE_CYCLES);
      cidx_n  = '0;
    end else if (busy) begin
      timer_n = timer - TM_W'(1);
      if (drain_open) cidx_n = cidx + CI_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld   <= '0;
      page  <= '0;
      timer <= '0;
      cidx  <= '0;
    end else begin
      vld   <= vld_n;
      page  <= page_n;
      timer <= timer_n;
      cidx  <= cidx_n;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_addr[PG_W-1:0]] <= buf_data;
  end

  always_ff @(posedge clk) begin
    if (drain_wr) mem[{page, cidx[PG_W-1:0]}] <= pbuf[cidx[PG_W-1:0]];
  end

  AST_WE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !busy); // R6
  AST_COMMIT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !busy); // R6
  AST_DRAIN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (cidx == CI_W'(PAGE_BYTES))); // R5

endmodule

// File: rtl/sms_proto.sv
module sms_proto
  import sms_pkg::*;
#(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned MEM_AW     = 10,
  parameter int unsigned PAGE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic              sel1,
  input  logic              sel2,
  input  logic              busy,
  input  logic [7:0]        rd_data,
  output logic              sda_drive_low,
  output logic              buf_clear,
  output logic              buf_we,
  output logic [MEM_AW-1:0] buf_addr,
  output logic [7:0]        buf_data,
  output logic              commit,
  output logic [MEM_AW-1:0] rd_addr
);

  localparam int unsigned PG_W = $clog2(PAGE_BYTES);
  localparam int unsigned HI_W = ADDR_W - BYTE_W;

  sms_state_e        st, st_n;
  logic [3:0]        cnt, cnt_n;
  logic [7:0]        sr, sr_n;
  logic [7:0]        txsr, txsr_n;
  logic [ADDR_W-1:0] ptr, ptr_n;
  logic [HI_W-1:0]   hi, hi_n;
  logic              first, first_n;
  logic              drv, drv_n;
  logic              mack, mack_n;
  logic [ADDR_W-1:0] wr_addr;
  logic              hdr_ok;

  assign wr_addr  = first ? ptr : {ptr[ADDR_W-1:PG_W], ptr[PG_W-1:0] + PG_W'(1)};
  assign hdr_ok   = (sr[7] == sel1) && (sr[6] == ~sel2);
  assign buf_addr = wr_addr[MEM_AW-1:0];
  assign buf_data = sr;
  assign rd_addr  = ptr[MEM_AW-1:0];
  assign sda_drive_low = drv;

  always_comb begin
    st_n = st; cnt_n = cnt; sr_n = sr; txsr_n = txsr; ptr_n = ptr;
    hi_n = hi; first_n = first; drv_n = drv; mack_n = mack;
    buf_clear = 1'b0; buf_we = 1'b0; commit = 1'b0;
    if (start_p) begin
      st_n = ST_HDR; cnt_n = '0; drv_n = 1'b0;
    end else if (stop_p) begin
      commit = (st == ST_WDAT) && (cnt <= 4'd1) && !first;
      st_n = ST_IDLE; drv_n = 1'b0;
    end else begin
      unique case (st)
        ST_HDR, ST_ALO, ST_WDAT: begin
          if (scl_rise && cnt != 4'd8) begin
            sr_n  = {sr[6:0], sda_q};
            cnt_n = cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (st == ST_HDR) begin
              if (hdr_ok && !busy) begin
                drv_n = 1'b1; st_n = ST_HACK; hi_n = sr[HI_W:1];
                buf_clear = !sr[0];
              end else begin
                st_n = ST_IDLE;
              end
            end else if (st == ST_ALO) begin
              ptr_n = {hi, sr}; first_n = 1'b1; drv_n = 1'b1; st_n = ST_AACK;
            end else begin
              buf_we = 1'b1; ptr_n = wr_addr; first_n = 1'b0;
              drv_n = 1'b1; st_n = ST_WACK;
            end
          end
        end
        ST_HACK, ST_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda_q;
          end else if (scl_fall) begin
            cnt_n = '0;
            if (st == ST_HACK && !sr[0]) begin
              drv_n = 1'b0; st_n = ST_ALO;
            end else if (st == ST_HACK || mack) begin
              txsr_n = rd_data; drv_n = ~rd_data[7];
              ptr_n = ptr + ADDR_W'(1); st_n = ST_RDAT;
            end else begin
              drv_n = 1'b0; st_n = ST_IDLE;
            end
          end
        end
        ST_AACK, ST_WACK: begin
          if (scl_fall) begin
            drv_n = 1'b0; cnt_n = '0; st_n = ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            cnt_n = cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              drv_n = 1'b0; st_n = ST_RACK;
            end else begin
              txsr_n = {txsr[6:0], 1'b0}; drv_n = ~txsr[6];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sr <= '0; txsr <= '0; ptr <= '0;
      hi <= '0; first <= 1'b1; drv <= 1'b0; mack <= 1'b0;
    end else begin
      st <= st_n; cnt <= cnt_n; sr <= sr_n; txsr <= txsr_n; ptr <= ptr_n;
      hi <= hi_n; first <= first_n; drv <= drv_n; mack <= mack_n;
    end
  end

  AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(scl_fall) |-> $stable(sda_drive_low)); // R1
  AST_RELEASE_IN_HOST_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RACK) |-> !sda_drive_low); // R10
  AST_NO_HDR_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HACK) |-> !busy); // R6

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave #(
  parameter int unsigned ADDR_W       = 13,
  parameter int unsigned MEM_AW       = 10,
  parameter int unsigned PAGE_BYTES   = 32,
  parameter int unsigned WRITE_CYCLES = 400,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda_in,
  input  logic sel1,
  input  logic sel2,
  output logic sda_drive_low
);

  logic [1:0]        rst_sh;
  logic              rst_ln;
  logic              sda_q, scl_rise, scl_fall, start_p, stop_p;
  logic              busy, buf_clear, buf_we, commit;
  logic [MEM_AW-1:0] buf_addr, rd_addr;
  logic [7:0]        buf_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= '0;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_ln = rst_sh[1];

  sms_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ln), .scl_i(scl), .sda_i(sda_in),
    .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  sms_proto #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .PAGE_BYTES(PAGE_BYTES)) u_proto (
    .clk(clk), .rst_n(rst_ln), .sda_q(sda_q), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
    .sel1(sel1), .sel2(sel2), .busy(busy), .rd_data(rd_data),
    .sda_drive_low(sda_drive_low), .buf_clear(buf_clear), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_data(buf_data), .commit(commit), .rd_addr(rd_addr)
  );

  sms_page_store #(.MEM_AW(MEM_AW), .PAGE_BYTES(PAGE_BYTES),
                   .WRITE_CYCLES(WRITE_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_ln), .buf_clear(buf_clear), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_data(buf_data), .commit(commit),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

endmodule

// File: tb/tb_serial_mem_slave.sv
module tb_serial_mem_slave;

  localparam int Q  = 10;
  localparam int WC = 400;

  logic clk = 1'b0;
  logic rst_n, scl, msda, sel1, sel2;
  logic sda_drive_low;
  logic sda_line;
  int   checks = 0;
  int   fails  = 0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  assign sda_line = msda & ~sda_drive_low;

  always #10 clk = ~clk;

  serial_mem_slave #(.WRITE_CYCLES(WC)) dut (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda_in(sda_line),
    .sel1(sel1), .sel2(sel2), .sda_drive_low(sda_drive_low)
  );

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] hdr(input logic [12:0] a, input logic rw);
    return {sel1, ~sel2, a[12:8], rw};
  endfunction

  task automatic bus_start();
    msda = 1'b1; wq(Q);
    if (!scl) begin scl = 1'b1; wq(Q); end
    msda = 1'b0; wq(Q);
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    if (scl) begin scl = 1'b0; wq(Q); end
    msda = 1'b0; wq(Q);
    scl = 1'b1; wq(Q);
    msda = 1'b1; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      wq(Q); msda = b[7-i]; wq(Q);
      scl = 1'b1; wq(Q);
      scl = 1'b0;
    end
  endtask

  task automatic get_ack(output bit a);
    wq(Q); msda = 1'b1; wq(Q);
    scl = 1'b1; wq(Q/2);
    a = !sda_line;
    wq(Q/2);
    scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit a);
    send_bits(b, 8);
    get_ack(a);
  endtask

  task automatic recv_byte(output logic [7:0] d, input bit give_ack);
    d = '0;
    for (int i = 0; i < 8; i++) begin
      wq(Q); msda = 1'b1; wq(Q);
      scl = 1'b1; wq(Q/2);
      d = {d[6:0], sda_line};
      wq(Q/2);
      scl = 1'b0;
    end
    wq(Q); msda = ~give_ack; wq(Q);
    scl = 1'b1; wq(Q);
    scl = 1'b0; wq(Q);
    msda = 1'b1;
  endtask

  task automatic do_write(input logic [12:0] a, input int n, input bit wait_done, input string tag);
    bit ak;
    bus_start();
    send_byte(hdr(a, 1'b0), ak);
    chk(ak, {tag, " R3 write header ack"}, ak, 1);
    send_byte(a[7:0], ak);
    chk(ak, {tag, " R3 address ack"}, ak, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ak);
      chk(ak, {tag, " R3 data ack"}, ak, 1);
    end
    bus_stop();
    if (wait_done) wq(WC + 50);
  endtask

  task automatic do_rread(input logic [12:0] a, input int n, input string tag);
    bit ak;
    bus_start();
    send_byte(hdr(a, 1'b0), ak);
    chk(ak, {tag, " R9 header ack"}, ak, 1);
    send_byte(a[7:0], ak);
    chk(ak, {tag, " R9 address ack"}, ak, 1);
    bus_start();
    send_byte(hdr(13'h0, 1'b1), ak);
    chk(ak, {tag, " R9 read header ack"}, ak, 1);
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i < n - 1);
    bus_stop();
  endtask

  task automatic do_cread(input int n, input string tag);
    bit ak;
    bus_start();
    send_byte(hdr(13'h0, 1'b1), ak);
    chk(ak, {tag, " R7 read header ack"}, ak, 1);
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i < n - 1);
    bus_stop();
  endtask

  task automatic t_reset();
    chk(sda_drive_low == 1'b0, "R1 line released after reset", sda_drive_low, 0);
  endtask

  task automatic t_no_start();
    bit ak;
    scl = 1'b0; wq(Q);
    send_byte(hdr(13'h0123, 1'b0), ak);
    chk(!ak, "R1 no ack without start", ak, 0);
    bus_stop();
  endtask

  task automatic t_select();
    bit ak;
    bus_start();
    send_byte({~sel1, ~sel2, 6'h00}, ak);
    chk(!ak, "R2 bit7 mismatch no ack", ak, 0);
    bus_stop();
    bus_start();
    send_byte({sel1, sel2, 6'h00}, ak);
    chk(!ak, "R2 bit6 not inverted no ack", ak, 0);
    bus_stop();
  endtask

  task automatic t_byte_write();
    wbuf[0] = 8'h5A;
    do_write(13'h0123, 1, 1'b1, "bytewr");
    do_rread(13'h0123, 1, "bytewr");
    chk(rbuf[0] == 8'h5A, "R5 R9 byte readback", rbuf[0], 8'h5A);
  endtask

  task automatic t_busy_poll();
    bit ak;
    wbuf[0] = 8'h77;
    do_write(13'h0060, 1, 1'b0, "busy");
    bus_start();
    send_byte(hdr(13'h0, 1'b0), ak);
    chk(!ak, "R6 no ack during write cycle", ak, 0);
    bus_stop();
    wq(WC);
    bus_start();
    send_byte(hdr(13'h0, 1'b0), ak);
    chk(ak, "R6 ack after write cycle", ak, 1);
    bus_stop();
  endtask

  task automatic t_page_wrap();
    wbuf[0] = 8'hA0; wbuf[1] = 8'hA1; wbuf[2] = 8'hA2; wbuf[3] = 8'hA3;
    do_write(13'h005E, 4, 1'b1, "page");
    do_rread(13'h005E, 2, "page");
    chk(rbuf[0] == 8'hA0, "R4 page byte at 0x5E", rbuf[0], 8'hA0);
    chk(rbuf[1] == 8'hA1, "R4 page byte at 0x5F", rbuf[1], 8'hA1);
    do_rread(13'h0040, 2, "page");
    chk(rbuf[0] == 8'hA2, "R4 wrapped byte at 0x40", rbuf[0], 8'hA2);
    chk(rbuf[1] == 8'hA3, "R4 wrapped byte at 0x41", rbuf[1], 8'hA3);
    do_rread(13'h0060, 1, "page");
    chk(rbuf[0] == 8'h77, "R4 next page untouched", rbuf[0], 8'h77);
  endtask

  task automatic t_current();
    wbuf[0] = 8'h9B;
    do_write(13'h0200, 1, 1'b1, "cur");
    do_cread(1, "cur");
    chk(rbuf[0] == 8'h9B, "R7 current read after write", rbuf[0], 8'h9B);
    do_rread(13'h005E, 1, "cur");
    do_cread(1, "cur");
    chk(rbuf[0] == 8'hA1, "R7 current read after read", rbuf[0], 8'hA1);
  endtask

  task automatic t_seq_wrap();
    wbuf[0] = 8'h3C;
    do_write(13'h1FFF, 1, 1'b1, "seq");
    wbuf[0] = 8'hC5;
    do_write(13'h0000, 1, 1'b1, "seq");
    do_rread(13'h1FFF, 2, "seq");
    chk(rbuf[0] == 8'h3C, "R8 byte at 0x1FFF", rbuf[0], 8'h3C);
    chk(rbuf[1] == 8'hC5, "R8 wrap to 0x0000", rbuf[1], 8'hC5);
    do_rread(13'h03FF, 1, "alias");
    chk(rbuf[0] == 8'h3C, "R12 alias of 0x1FFF at 0x03FF", rbuf[0], 8'h3C);
  endtask

  task automatic t_nack_release();
    bit ak;
    int ones;
    logic [7:0] d;
    bus_start();
    send_byte(hdr(13'h0123, 1'b0), ak);
    send_byte(8'h23, ak);
    bus_start();
    send_byte(hdr(13'h0, 1'b1), ak);
    recv_byte(d, 1'b0);
    chk(d == 8'h5A, "R10 byte before host nack", d, 8'h5A);
    ones = 0;
    for (int i = 0; i < 9; i++) begin
      wq(Q); msda = 1'b1; wq(Q);
      scl = 1'b1; wq(Q/2);
      if (sda_line) ones++;
      wq(Q/2);
      scl = 1'b0;
    end
    chk(ones == 9, "R10 line released after nack", ones, 9);
    bus_stop();
    bus_start();
    send_byte(hdr(13'h0, 1'b0), ak);
    chk(ak, "R10 responds after next start", ak, 1);
    bus_stop();
  endtask

  task automatic t_abort();
    bit ak;
    bus_start();
    send_byte(hdr(13'h0123, 1'b0), ak);
    send_byte(8'h23, ak);
    send_bits(8'h00, 3);
    bus_stop();
    bus_start();
    send_byte(hdr(13'h0, 1'b0), ak);
    chk(ak, "R11 no write cycle after abort", ak, 1);
    bus_stop();
    do_rread(13'h0123, 1, "abort");
    chk(rbuf[0] == 8'h5A, "R11 array unchanged", rbuf[0], 8'h5A);
  endtask

  task automatic t_restart_header();
    bit ak;
    sel2 = 1'b1;
    bus_start();
    send_bits(hdr(13'h0, 1'b0), 4);
    bus_start();
    send_byte(hdr(13'h0, 1'b0), ak);
    chk(ak, "R1 R2 restart mid header, sel2 high", ak, 1);
    bus_stop();
    sel2 = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R1 actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; scl = 1'b1; msda = 1'b1; sel1 = 1'b1; sel2 = 1'b0;
    wq(5);
    rst_n = 1'b1;
    wq(5);
    t_reset();
    t_no_start();
    t_select();
    t_byte_write();
    t_busy_poll();
    t_page_wrap();
    t_current();
    t_seq_wrap();
    t_nack_release();
    t_abort();
    t_restart_header();
    summary();
    $finish;
  end

endmodule